// File: doc/BRIEF.md
# SIMD Lane Array with Per-Lane Addressing and Enable

This block is a row of identical processing lanes that all obey one broadcast instruction stream. A controller hands the array one instruction at a time over a valid/ready handshake. Each instruction carries an opcode, a base address, an immediate value and the current central index value. Each lane keeps its own accumulator, its own local index register, a small test-result register and a private local memory. Each lane therefore touches a different word of its own memory for the same instruction, because the address it uses is the sum of the shared base, the central index and its own local index.

Branching is replaced by masking. Compare instructions run in every lane against the broadcast immediate and leave their outcome in the test-result register. The enable field of that register decides whether the lane carries out the data instructions that follow. An enable-all instruction brings every lane back into play. Any value the lanes use in common comes in as the immediate of the instruction that needs it, so no lane reads it from memory.

Each instruction takes two cycles. In the accept cycle the addresses are formed and registered. In the execute cycle the lanes read or write memory and update their registers. During the execute cycle ready is held low.

Top module: `simd_lane_array`

## Requirements
- R1: A lane's operand address equals instr_base plus central_idx plus that lane's local index. The sum wraps modulo the local memory depth (2^ADDR_W words).
- R2: A lane whose enable bit is 0 changes neither its accumulator, its local index nor its memory on a data instruction.
- R3: A compare writes the test-result register in every lane, enabled or not. It sets lt to (acc < imm) and eq to (acc == imm), unsigned. Compare-equal (opcode 8) loads enable with eq. Compare-less (opcode 9) loads enable with lt.
- R4: And-less (opcode 10) sets enable to the old enable AND (acc < imm), and it writes lt and eq the same way as the other compares.
- R5: Enable-all (opcode 15) sets the enable bit of every lane to 1.
- R6: Add (opcode 3) sets acc to acc plus the broadcast immediate, modulo 2^DATA_W.
- R7: An instruction is taken on a clock edge where instr_valid and instr_ready are both 1. instr_ready is 0 for exactly the following cycle. Lane state changes only on the edge that ends that cycle.
- R8: After reset and two clock edges, every accumulator and local index is 0, every enable bit is 1, every lt and eq is 0, and instr_ready is 1.
- R9: Set-index (opcode 6) loads the local index with the low ADDR_W bits of the accumulator.
- R10: Load (opcode 1) sets acc to mem[addr]. Store (opcode 2) writes acc to mem[addr]. Load-immediate (opcode 4) sets acc to imm. Lane-number (opcode 5) sets acc to the lane's position, counting from 0. Opcode 0 and unused codes do nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| instr_valid | input | 1 | Broadcast instruction present |
| instr_ready | output | 1 | Array can take an instruction this cycle |
| instr_op | input | 4 | Opcode |
| instr_base | input | ADDR_W | Base address |
| instr_imm | input | DATA_W | Broadcast common operand |
| central_idx | input | ADDR_W | Central index value |
| lane_acc_o | output | LANES*DATA_W | Accumulators, lane 0 in the low bits |
| lane_idx_o | output | LANES*ADDR_W | Local index registers, lane 0 in the low bits |
| lane_en_o | output | LANES | Enable bit of each lane |
| lane_lt_o | output | LANES | Last less-than result of each lane |
| lane_eq_o | output | LANES | Last equal result of each lane |

## Verification
The hardest case to reach from the ports is a disabled lane that holds a local index, an accumulator and memory contents all different from its enabled neighbours. Only that lane shows whether a store, an add or a set-index leaked through the mask. The stimulus gives every lane a distinct index from its lane number and then uses compare-equal to leave a single lane enabled. Stores, adds and a set-index then run against that lone lane. Enable-all and a load from the pre-loaded addresses follow, so every lane's memory word is brought back out through the accumulator. Wrapping of the three-term address sum is reached by choosing base and central values whose total passes the memory depth. A store and a load that reach the same word only after wrapping are then compared.

// File: rtl/simd_pkg.sv
package simd_pkg;

  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_LDA   = 4'd1,
    OP_STA   = 4'd2,
    OP_ADD   = 4'd3,
    OP_LDI   = 4'd4,
    OP_LID   = 4'd5,
    OP_SETX  = 4'd6,
    OP_CMPEQ = 4'd8,
    OP_CMPLT = 4'd9,
    OP_ANDLT = 4'd10,
    OP_ENALL = 4'd15
  } op_e;

  // per-lane test-result register; enable is one of its fields
  typedef struct packed {
    logic eq;
    logic lt;
    logic en;
  } test_t;

  function automatic logic is_test_op(input op_e op);
    return (op == OP_CMPEQ) || (op == OP_CMPLT) ||
           (op == OP_ANDLT) || (op == OP_ENALL);
  endfunction

endpackage

// File: rtl/simd_issue.sv
module simd_issue
  import simd_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  op_e               in_op,
  input  logic [ADDR_W-1:0] in_base,
  input  logic [DATA_W-1:0] in_imm,
  input  logic [ADDR_W-1:0] in_cidx,
  output logic              accept_o,
  output logic [ADDR_W-1:0] shared_sum_o,
  output logic              exec_o,
  output op_e               op_o,
  output logic [DATA_W-1:0] imm_o
);

  logic              exec_q, exec_d;
  op_e               op_q, op_d;
  logic [DATA_W-1:0] imm_q, imm_d;

  assign in_ready     = rst_n & ~exec_q;
  assign accept_o     = in_valid & in_ready;
  // base plus central index is common to all lanes: formed once here
  assign shared_sum_o = in_base + in_cidx;

  always_comb begin
    exec_d = accept_o;
    op_d   = op_q;
    imm_d  = imm_q;
    if (accept_o) begin
      op_d  = in_op;
      imm_d = in_imm;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exec_q <= 1'b0;
      op_q   <= OP_NOP;
      imm_q  <= '0;
    end else begin
      exec_q <= exec_d;
      op_q   <= op_d;
      imm_q  <= imm_d;
    end
  end

  assign exec_o = exec_q;
  assign op_o   = op_q;
  assign imm_o  = imm_q;

endmodule

// File: rtl/simd_addr_gen.sv
module simd_addr_gen #(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] shared_sum,
  input  logic [ADDR_W-1:0] local_idx,
  output logic [ADDR_W-1:0] eff_addr
);

  // carry out of the top bit is dropped: wraps modulo the memory depth
  assign eff_addr = shared_sum + local_idx;

endmodule

// File: rtl/simd_lane.sv
module simd_lane
  import simd_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 16,
  parameter int LANE_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] shared_sum,
  input  logic              exec,
  input  op_e               op,
  input  logic [DATA_W-1:0] imm,
  output logic [DATA_W-1:0] acc_o,
  output logic [ADDR_W-1:0] idx_o,
  output test_t             test_o
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] acc_q, acc_d;
  logic [ADDR_W-1:0] idx_q, idx_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  test_t             test_q, test_d;
  logic              mem_we;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_data;
  logic [ADDR_W-1:0] eff_addr;
  logic              lt_r, eq_r;

  simd_addr_gen #(.ADDR_W(ADDR_W)) u_agen (
    .shared_sum (shared_sum),
    .local_idx  (idx_q),
    .eff_addr   (eff_addr)
  );

  assign rd_data = mem[addr_q];
  assign lt_r    = acc_q < imm;
  assign eq_r    = acc_q == imm;

  always_comb begin
    addr_d = accept ? eff_addr : addr_q;
    acc_d  = acc_q;
    idx_d  = idx_q;
    test_d = test_q;
    mem_we = 1'b0;
    if (exec) begin
      unique case (op)
        OP_CMPEQ: begin
          test_d.lt = lt_r;
          test_d.eq = eq_r;
          test_d.en = eq_r;
        end
        OP_CMPLT: begin
          test_d.lt = lt_r;
          test_d.eq = eq_r;
          test_d.en = lt_r;
        end
        OP_ANDLT: begin
          test_d.lt = lt_r;
          test_d.eq = eq_r;
          test_d.en = test_q.en & lt_r;
        end
        OP_ENALL: test_d.en = 1'b1;
        default: begin
          if (test_q.en) begin
            unique case (op)
              OP_LDA:  acc_d  = rd_data;
              OP_STA:  mem_we = 1'b1;
              OP_ADD:  acc_d  = acc_q + imm;
              OP_LDI:  acc_d  = imm;
              OP_LID:  acc_d  = DATA_W'(LANE_ID);
              OP_SETX: idx_d  = acc_q[ADDR_W-1:0];
              default: ;
            endcase
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= '0;
      idx_q     <= '0;
      addr_q    <= '0;
      test_q.en <= 1'b1;
      test_q.lt <= 1'b0;
      test_q.eq <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      idx_q  <= idx_d;
      addr_q <= addr_d;
      test_q <= test_d;
    end
  end

  // local memory: no reset, written only with its clock enable
  always_ff @(posedge clk) begin
    if (mem_we) mem[addr_q] <= acc_q;
  end

  assign acc_o  = acc_q;
  assign idx_o  = idx_q;
  assign test_o = test_q;

endmodule

// File: rtl/simd_lane_array.sv
module simd_lane_array
  import simd_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     instr_valid,
  output logic                     instr_ready,
  input  logic [3:0]               instr_op,
  input  logic [ADDR_W-1:0]        instr_base,
  input  logic [DATA_W-1:0]        instr_imm,
  input  logic [ADDR_W-1:0]        central_idx,
  output logic [LANES*DATA_W-1:0]  lane_acc_o,
  output logic [LANES*ADDR_W-1:0]  lane_idx_o,
  output logic [LANES-1:0]         lane_en_o,
  output logic [LANES-1:0]         lane_lt_o,
  output logic [LANES-1:0]         lane_eq_o
);

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic              accept;
  logic [ADDR_W-1:0] shared_sum;
  logic              exec_q;
  op_e               op_q;
  logic [DATA_W-1:0] imm_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  simd_issue #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_issue (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .in_valid     (instr_valid),
    .in_ready     (instr_ready),
    .in_op        (op_e'(instr_op)),
    .in_base      (instr_base),
    .in_imm       (instr_imm),
    .in_cidx      (central_idx),
    .accept_o     (accept),
    .shared_sum_o (shared_sum),
    .exec_o       (exec_q),
    .op_o         (op_q),
    .imm_o        (imm_q)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    test_t t;
    simd_lane #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_ID(g)) u_lane (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .accept     (accept),
      .shared_sum (shared_sum),
      .exec       (exec_q),
      .op         (op_q),
      .imm        (imm_q),
      .acc_o      (lane_acc_o[g*DATA_W +: DATA_W]),
      .idx_o      (lane_idx_o[g*ADDR_W +: ADDR_W]),
      .test_o     (t)
    );
    assign lane_en_o[g] = t.en;
    assign lane_lt_o[g] = t.lt;
    assign lane_eq_o[g] = t.eq;
  end

endmodule

// File: rtl/simd_lane_array_chk.sv
module simd_lane_array_chk
  import simd_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    instr_valid,
  input logic                    instr_ready,
  input logic                    exec_q,
  input op_e                     op_q,
  input logic [LANES*DATA_W-1:0] lane_acc,
  input logic [LANES*ADDR_W-1:0] lane_idx,
  input logic [LANES-1:0]        lane_en,
  input logic [LANES-1:0]        lane_eq
);

  assert_accept_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && instr_ready) |=> !instr_ready);

  assert_stall_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_ready |=> instr_ready);

  assert_quiet_acc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_q |=> ($stable(lane_acc) && $stable(lane_idx)));

  assert_enall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_q && op_q == OP_ENALL) |=> (&lane_en));

  assert_cmpeq_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_q && op_q == OP_CMPEQ) |=> (lane_en == lane_eq));

  for (genvar g = 0; g < LANES; g++) begin : g_mask
    assert_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_q && !lane_en[g] && !is_test_op(op_q)) |=>
        ($stable(lane_acc[g*DATA_W +: DATA_W]) &&
         $stable(lane_idx[g*ADDR_W +: ADDR_W])));
  end

endmodule

bind simd_lane_array simd_lane_array_chk #(
  .LANES(LANES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .instr_valid (instr_valid),
  .instr_ready (instr_ready),
  .exec_q      (exec_q),
  .op_q        (op_q),
  .lane_acc    (lane_acc_o),
  .lane_idx    (lane_idx_o),
  .lane_en     (lane_en_o),
  .lane_eq     (lane_eq_o)
);

// File: tb/sim_simd_lane_array.sv
module sim_simd_lane_array;

  localparam int LANES  = 8;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 16;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG_CYCLES = 20000;

  localparam logic [3:0] NOP = 4'd0, LDA = 4'd1, STA = 4'd2, ADD = 4'd3,
                         LDI = 4'd4, LID = 4'd5, SETX = 4'd6, CMPEQ = 4'd8,
                         CMPLT = 4'd9, ANDLT = 4'd10, ENALL = 4'd15;

  typedef struct packed {
    logic [3:0]  op;
    logic [3:0]  base;
    logic [3:0]  cidx;
    logic [15:0] imm;
    logic [7:0]  amask;  // lanes that take ehi, the others take elo
    logic [15:0] ehi;
    logic [15:0] elo;
    logic        step;   // add the lane number to the expectation
    logic [7:0]  en;
  } vec_t;

  localparam int NVEC = 17;
  localparam vec_t VECS [NVEC] = '{
    '{LID,   4'd0,  4'd0,  16'd0,   8'hff, 16'd0,   16'd0, 1'b1, 8'hff}, // R10
    '{ADD,   4'd0,  4'd0,  16'd10,  8'hff, 16'd10,  16'd0, 1'b1, 8'hff}, // R6
    '{SETX,  4'd0,  4'd0,  16'd0,   8'hff, 16'd10,  16'd0, 1'b1, 8'hff}, // R9
    '{STA,   4'd0,  4'd0,  16'd0,   8'hff, 16'd10,  16'd0, 1'b1, 8'hff}, // R10
    '{LDI,   4'd0,  4'd0,  16'd0,   8'hff, 16'd0,   16'd0, 1'b0, 8'hff}, // R10
    '{LDA,   4'd0,  4'd0,  16'd0,   8'hff, 16'd10,  16'd0, 1'b1, 8'hff}, // R1
    '{LDI,   4'd0,  4'd0,  16'd100, 8'hff, 16'd100, 16'd0, 1'b0, 8'hff}, // R10
    '{STA,   4'd3,  4'd4,  16'd0,   8'hff, 16'd100, 16'd0, 1'b0, 8'hff}, // R1 wrap
    '{LID,   4'd0,  4'd0,  16'd0,   8'hff, 16'd0,   16'd0, 1'b1, 8'hff}, // R10
    '{LDA,   4'd12, 4'd11, 16'd0,   8'hff, 16'd100, 16'd0, 1'b0, 8'hff}, // R1 wrap
    '{LID,   4'd0,  4'd0,  16'd0,   8'hff, 16'd0,   16'd0, 1'b1, 8'hff}, // R10
    '{CMPLT, 4'd0,  4'd0,  16'd3,   8'hff, 16'd0,   16'd0, 1'b1, 8'h07}, // R3
    '{ADD,   4'd0,  4'd0,  16'd50,  8'h07, 16'd50,  16'd0, 1'b1, 8'h07}, // R2
    '{CMPLT, 4'd0,  4'd0,  16'd6,   8'h07, 16'd50,  16'd0, 1'b1, 8'h38}, // R3
    '{ANDLT, 4'd0,  4'd0,  16'd5,   8'h07, 16'd50,  16'd0, 1'b1, 8'h18}, // R4
    '{ENALL, 4'd0,  4'd0,  16'd0,   8'h07, 16'd50,  16'd0, 1'b1, 8'hff}, // R5
    '{CMPEQ, 4'd0,  4'd0,  16'd51,  8'h07, 16'd50,  16'd0, 1'b1, 8'h02}  // R3
  };

  logic                    clk;
  logic                    rst_n;
  logic                    instr_valid;
  logic                    instr_ready;
  logic [3:0]              instr_op;
  logic [ADDR_W-1:0]       instr_base;
  logic [DATA_W-1:0]       instr_imm;
  logic [ADDR_W-1:0]       central_idx;
  logic [LANES*DATA_W-1:0] lane_acc_o;
  logic [LANES*ADDR_W-1:0] lane_idx_o;
  logic [LANES-1:0]        lane_en_o;
  logic [LANES-1:0]        lane_lt_o;
  logic [LANES-1:0]        lane_eq_o;

  int n_checks = 0;
  int n_fail   = 0;

  simd_lane_array #(.LANES(LANES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_ready(instr_ready),
    .instr_op(instr_op), .instr_base(instr_base), .instr_imm(instr_imm),
    .central_idx(central_idx), .lane_acc_o(lane_acc_o), .lane_idx_o(lane_idx_o),
    .lane_en_o(lane_en_o), .lane_lt_o(lane_lt_o), .lane_eq_o(lane_eq_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string what, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic issue(input logic [3:0] op, input logic [3:0] base,
                       input logic [3:0] cidx, input logic [15:0] imm);
    @(negedge clk);
    while (!instr_ready) @(negedge clk);
    instr_op    = op;
    instr_base  = base;
    central_idx = cidx;
    instr_imm   = imm;
    instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [127:0] acc_vec(input logic [7:0] amask, input logic [15:0] hi,
                                           input logic [15:0] lo, input logic step);
    logic [127:0] v = '0;
    for (int i = 0; i < LANES; i++)
      v[i*16 +: 16] = (amask[i] ? hi : lo) + (step ? 16'(i) : 16'd0);
    return v;
  endfunction

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [127:0] e;
    instr_valid = 1'b0;
    instr_op    = NOP;
    instr_base  = '0;
    instr_imm   = '0;
    central_idx = '0;
    rst_n       = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R8: reset state
    check("R8 acc",   128'(lane_acc_o), '0);
    check("R8 idx",   128'(lane_idx_o), '0);
    check("R8 en",    128'(lane_en_o),  128'(8'hff));
    check("R8 lt/eq", 128'({lane_lt_o, lane_eq_o}), '0);
    check("R8 ready", 128'(instr_ready), 128'(1'b1));

    // vector table
    for (int k = 0; k < NVEC; k++) begin
      issue(VECS[k].op, VECS[k].base, VECS[k].cidx, VECS[k].imm);
      check($sformatf("vec %0d op %0d acc (R1/R2/R6/R9/R10)", k, VECS[k].op),
            128'(lane_acc_o), acc_vec(VECS[k].amask, VECS[k].ehi, VECS[k].elo, VECS[k].step));
      check($sformatf("vec %0d op %0d enable (R3/R4/R5)", k, VECS[k].op),
            128'(lane_en_o), 128'(VECS[k].en));
    end

    // R3: flags after compare-equal 51; acc = 50,51,52,3..7
    check("R3 lt flags", 128'(lane_lt_o), 128'(8'hf9));
    check("R3 eq flags", 128'(lane_eq_o), 128'(8'h02));

    // R2: only lane 1 enabled; add, set-index, store must touch lane 1 only
    issue(ADD, 4'd0, 4'd0, 16'd1001);
    e = acc_vec(8'h07, 16'd50, 16'd0, 1'b1);
    e[16 +: 16] = 16'd1052;
    check("R2 masked add", 128'(lane_acc_o), e);
    issue(SETX, 4'd0, 4'd0, 16'd0);
    e = '0;
    for (int i = 0; i < LANES; i++) e[i*4 +: 4] = 4'(10 + i);
    e[4 +: 4] = 4'd12;
    check("R2 R9 masked set-index", 128'(lane_idx_o), e);
    issue(STA, 4'd0, 4'd0, 16'd0);
    issue(ENALL, 4'd0, 4'd0, 16'd0);
    issue(LDA, 4'd0, 4'd0, 16'd0);
    e = acc_vec(8'hff, 16'd10, 16'd0, 1'b1);
    e[16 +: 16] = 16'd1052;
    check("R2 masked store left memory", 128'(lane_acc_o), e);

    // R6: wrap of add
    issue(LDI, 4'd0, 4'd0, 16'hfff0);
    issue(ADD, 4'd0, 4'd0, 16'h0020);
    check("R6 add wraps", 128'(lane_acc_o), acc_vec(8'hff, 16'h0010, 16'd0, 1'b0));

    // R7: valid held high across the stall cycle is taken once
    @(negedge clk);
    instr_op = ADD; instr_base = '0; central_idx = '0; instr_imm = 16'd1;
    instr_valid = 1'b1;
    @(negedge clk);
    check("R7 ready low after accept", 128'(instr_ready), 128'(1'b0));
    @(negedge clk);
    check("R7 ready back high", 128'(instr_ready), 128'(1'b1));
    check("R7 executed once", 128'(lane_acc_o), acc_vec(8'hff, 16'h0011, 16'd0, 1'b0));
    instr_valid = 1'b0;
    @(negedge clk);
    check("R7 no accept without valid", 128'(lane_acc_o), acc_vec(8'hff, 16'h0011, 16'd0, 1'b0));

    finish_run();
  end

endmodule